// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter Stage

This block is a four-bit counter with two separate count clocks, one that steps the value up and one that steps it down. A parameter builds it either as a decade counter (digits 0 to 9) or as a modulo-16 binary counter. Software-free control comes from a level-sensitive parallel load that copies four preset bits into the count and a master clear that forces zero over every other input. Both the load and the clear show on the count output in the same cycle they are applied.

The count clocks are slow external strobes. They are sampled by one fast system clock through a two-flop synchronizer, and rising edges are detected on the synchronized levels. Two active-low terminal-count strobes, carry and borrow, are low only during the low phase of the matching count clock at the top and bottom codes. Their rising edge therefore coincides with the wrap, so stages can be chained by wiring carry to the next stage's up clock and borrow to its down clock. In decade mode an out-of-range code (10 to 15) returns to a legal digit on the next count.

Top module: `updn_stage`

## Requirements
- R1: While clr is high the count output is 0 in the same cycle, whatever load_n, the preset bits and the count clocks do, and the count stays 0 after clr falls if load_n is high.
- R2: While clr is low and load_n is low the count output equals preset in the same cycle, and it keeps that value after load_n returns high.
- R3: A rising edge on up_clk while dn_clk is high adds one to the count within five system clock cycles.
- R4: A rising edge on dn_clk while up_clk is high subtracts one from the count within five system clock cycles.
- R5: A rising edge on one count clock while the other count clock is low leaves the count unchanged.
- R6: The top code is 9 when DECADE is 1 and 15 when DECADE is 0; counting up from the top code gives 0 and counting down from 0 gives the top code.
- R7: carry_n is low exactly while the count equals the top code and the synchronized up_clk level is low; it goes high with the up edge that produces 0.
- R8: borrow_n is low exactly while the count is 0 and the synchronized dn_clk level is low; it goes high with the down edge that produces the top code.
- R9: With DECADE at 1, a count holding a code from 10 to 15 goes to 0 on an up count and to 9 on a down count.
- R10: Two stages chained carry_n to up_clk and borrow_n to dn_clk count as one eight-bit counter: a wrap of the low stage steps the high stage in the same direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Master clear, active high, highest priority |
| load_n | input | 1 | Parallel load, active low, level sensitive |
| preset | input | 4 | Value copied into the count during a load |
| up_clk | input | 1 | Count-up strobe, counts on its rising edge |
| dn_clk | input | 1 | Count-down strobe, counts on its rising edge |
| count | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal count for up counting |
| borrow_n | output | 1 | Active-low terminal count for down counting |

## Verification
The clear and the load can be active in the very cycle a count edge is detected, and all three can coincide. The bench holds load_n low with a preset value, raises clr and drives a full up_clk strobe underneath, then expects 0 both at once and after the strobe; dropping clr with load_n still low must show the preset at once, and releasing load_n must keep it, so neither the clear nor the edge may leak through. A second overlap, a count edge arriving while the opposite clock is low, is judged by the count staying put until a legal edge follows.

// File: rtl/updn_pkg.sv
// Shared types and next-code arithmetic for the up/down counter stage.
// Assumes a four-bit count; decade mode keeps the codes 0..9 legal.
package updn_pkg;

    localparam int unsigned CNT_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t DEC_MAX = cnt_t'(9);
    localparam cnt_t BIN_MAX = '1;

    // Highest legal code for the chosen radix.
    function automatic cnt_t top_code(input bit decade);
        return decade ? DEC_MAX : BIN_MAX;
    endfunction

    // Next code on an up count; the top code and any illegal code go to zero.
    function automatic cnt_t step_up(input cnt_t v, input bit decade);
        if (v >= top_code(decade))
            return '0;
        return v + cnt_t'(1);
    endfunction

    // Next code on a down count; zero wraps, illegal decade codes go to nine.
    function automatic cnt_t step_down(input cnt_t v, input bit decade);
        if (decade && (v > DEC_MAX))
            return DEC_MAX;
        if (v == '0)
            return top_code(decade);
        return v - cnt_t'(1);
    endfunction

endpackage

// File: rtl/edge_sync.sv
// Synchronizes N slow strobes into the system clock domain and flags the
// cycle in which each synchronized level rises.
// Assumes the strobes idle high, so the chain resets to one.
module edge_sync #(
    parameter int unsigned N      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise
);

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic [STAGES-1:0] sh;
        logic              prev;

        // Shift the raw strobe through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[STAGES-2:0], async_in[i]};
        end

        // Keep last cycle's synchronized level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev <= 1'b1;
            else        prev <= sh[STAGES-1];
        end

        assign level[i] = sh[STAGES-1];
        assign rise[i]  = sh[STAGES-1] & ~prev;
    end

endmodule

// File: rtl/count_core.sv
// Count register with clear, parallel load and single-step up/down.
// Clear and load act on the output in the same cycle and are also
// captured by the register; simultaneous up and down requests cancel.
module count_core
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load_n,
    input  cnt_t preset,
    input  logic inc,
    input  logic dec,
    output cnt_t count
);

    cnt_t cnt_q;
    cnt_t cnt_d;

    // Pick the next code by priority: clear, load, single step, hold.
    always_comb begin
        if (clr)
            cnt_d = '0;
        else if (!load_n)
            cnt_d = preset;
        else if (inc && !dec)
            cnt_d = step_up(cnt_q, DECADE);
        else if (dec && !inc)
            cnt_d = step_down(cnt_q, DECADE);
        else
            cnt_d = cnt_q;
    end

    // Hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Let clear and load reach the output without waiting for an edge.
    always_comb begin
        if (clr)          count = '0;
        else if (!load_n) count = preset;
        else              count = cnt_q;
    end

endmodule

// File: rtl/tc_decode.sv
// Active-low terminal-count strobes, gated by the low phase of the
// synchronized count clocks so that their rise matches the wrap.
module tc_decode
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  cnt_t count,
    input  logic up_lvl,
    input  logic dn_lvl,
    output logic carry_n,
    output logic borrow_n
);

    localparam cnt_t TOP = top_code(DECADE);

    // Decode top and bottom codes against the clock levels.
    always_comb begin
        carry_n  = ~((count == TOP) & ~up_lvl);
        borrow_n = ~((count == '0)  & ~dn_lvl);
    end

endmodule

// File: rtl/updn_stage.sv
// Dual-clock presettable up/down counter stage, decade or binary by
// parameter. Count strobes are sampled by clk; an edge counts only when
// the opposite strobe is high. Stages chain carry_n/borrow_n to the next
// stage's up_clk/dn_clk.
module updn_stage
    import updn_pkg::*;
#(
    parameter bit          DECADE      = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [CNT_W-1:0] preset,
    input  logic             up_clk,
    input  logic             dn_clk,
    output logic [CNT_W-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam int unsigned UP = 0;
    localparam int unsigned DN = 1;

    logic [1:0] lvl;
    logic [1:0] rise;
    logic       inc;
    logic       dec;
    cnt_t       cnt_w;

    edge_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dn_clk, up_clk}),
        .level    (lvl),
        .rise     (rise)
    );

    // Qualify each edge with the other strobe's high level.
    always_comb begin
        inc = rise[UP] & lvl[DN];
        dec = rise[DN] & lvl[UP];
    end

    count_core #(.DECADE(DECADE)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .load_n (load_n),
        .preset (preset),
        .inc    (inc),
        .dec    (dec),
        .count  (cnt_w)
    );

    tc_decode #(.DECADE(DECADE)) u_tc (
        .count    (cnt_w),
        .up_lvl   (lvl[UP]),
        .dn_lvl   (lvl[DN]),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    assign count = cnt_w;

endmodule

// File: rtl/updn_stage_chk.sv
// Port-level properties of the counter stage, bound to every instance.
module updn_stage_chk
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic load_n,
    input cnt_t preset,
    input cnt_t count,
    input logic carry_n,
    input logic borrow_n
);

    localparam cnt_t TOP = top_code(DECADE);

    // R1: after a clear is dropped with no load, zero was retained.
    a_r1_clear_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) && !clr && load_n) |-> (count == '0));

    // R2: the preset captured during the last load cycle is kept.
    a_r2_load_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!clr && !load_n) && !clr && load_n) |-> (count == $past(preset)));

    // R6: a legal decade code never steps outside the legal range.
    a_r6_decade_range: assert property (@(posedge clk) disable iff (!rst_n)
        (DECADE && load_n && $past(load_n) && ($past(count) <= DEC_MAX))
        |-> (count <= DEC_MAX));

    // R7: carry strobe only at the top code.
    a_r7_carry_top: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count == TOP));

    // R8: borrow strobe only at zero.
    a_r8_borrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count == '0));

    // R9: leaving an illegal decade code lands on 0 or 9.
    a_r9_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (DECADE && !clr && load_n && $past(load_n) && !$past(clr)
         && ($past(count) > DEC_MAX) && (count != $past(count)))
        |-> ((count == '0) || (count == DEC_MAX)));

endmodule

bind updn_stage updn_stage_chk #(.DECADE(DECADE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load_n   (load_n),
    .preset   (preset),
    .count    (count),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
);

// File: tb/sim_updn_stage.sv
// Directed bench: a decade stage (u0) and a chained pair of binary stages.
module sim_updn_stage;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic       clr0 = 1'b0, ld0 = 1'b1, up0 = 1'b1, dn0 = 1'b1;
    logic [3:0] p0 = '0;
    logic [3:0] q0;
    logic       cy0, bw0;

    logic       clr1 = 1'b0, ld1 = 1'b1, up1 = 1'b1, dn1 = 1'b1;
    logic [3:0] p1 = '0;
    logic [3:0] qlo, qhi;
    logic       cylo, bwlo, cyhi, bwhi;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    updn_stage #(.DECADE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr0), .load_n(ld0), .preset(p0),
        .up_clk(up0), .dn_clk(dn0), .count(q0), .carry_n(cy0), .borrow_n(bw0)
    );

    updn_stage #(.DECADE(1'b0)) u_lo (
        .clk(clk), .rst_n(rst_n), .clr(clr1), .load_n(ld1), .preset(p1),
        .up_clk(up1), .dn_clk(dn1), .count(qlo), .carry_n(cylo), .borrow_n(bwlo)
    );

    updn_stage #(.DECADE(1'b0)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr(clr1), .load_n(1'b1), .preset(4'd0),
        .up_clk(cylo), .dn_clk(bwlo), .count(qhi), .carry_n(cyhi), .borrow_n(bwhi)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // which: 0 up0, 1 dn0, 2 up1, 3 dn1; full low-then-high strobe.
    task automatic strobe(input int which);
        case (which)
            0: up0 = 1'b0;
            1: dn0 = 1'b0;
            2: up1 = 1'b0;
            default: dn1 = 1'b0;
        endcase
        idle(10);
        case (which)
            0: up0 = 1'b1;
            1: dn0 = 1'b1;
            2: up1 = 1'b1;
            default: dn1 = 1'b1;
        endcase
        idle(10);
    endtask

    task automatic load0(input logic [3:0] v);
        p0 = v; ld0 = 1'b0;
        #1 chk("R2 immediate load", int'(q0), int'(v));
        idle(2);
        ld0 = 1'b1;
        idle(1);
        chk("R2 load kept", int'(q0), int'(v));
    endtask

    task automatic t_reset();
        chk("reset count", int'(q0), 0);
        chk("reset carry_n", int'(cy0), 1);
        chk("reset borrow_n", int'(bw0), 1);
    endtask

    task automatic t_decade_run();
        load0(4'd7);
        strobe(0); chk("R3 up to 8", int'(q0), 8);
        strobe(0); chk("R3 up to 9", int'(q0), 9);
        up0 = 1'b0; idle(10);
        chk("R7 carry low at 9", int'(cy0), 0);
        up0 = 1'b1; idle(10);
        chk("R6 decade wrap up", int'(q0), 0);
        chk("R7 carry released", int'(cy0), 1);
        strobe(0); strobe(0);
        chk("R3 up to 2", int'(q0), 2);
        strobe(1); chk("R4 down to 1", int'(q0), 1);
        strobe(1); chk("R4 down to 0", int'(q0), 0);
        dn0 = 1'b0; idle(10);
        chk("R8 borrow low at 0", int'(bw0), 0);
        dn0 = 1'b1; idle(10);
        chk("R6 decade wrap down", int'(q0), 9);
        chk("R8 borrow released", int'(bw0), 1);
        strobe(1); strobe(1);
        chk("R4 down to 7", int'(q0), 7);
    endtask

    task automatic t_ignore();
        up0 = 1'b0; idle(10);
        dn0 = 1'b0; idle(10);
        up0 = 1'b1; idle(10);
        chk("R5 up edge with down low ignored", int'(q0), 7);
        dn0 = 1'b1; idle(10);
        chk("R4 down edge after ignore", int'(q0), 6);
    endtask

    task automatic t_clear_overlap();
        p0 = 4'd5; ld0 = 1'b0; clr0 = 1'b1;
        #1 chk("R1 clear beats load", int'(q0), 0);
        strobe(0);
        chk("R1 clear beats up edge", int'(q0), 0);
        clr0 = 1'b0;
        #1 chk("R2 load after clear", int'(q0), 5);
        idle(1);
        ld0 = 1'b1; idle(1);
        chk("R2 kept after overlap", int'(q0), 5);
        clr0 = 1'b1; idle(2); clr0 = 1'b0; idle(1);
        chk("R1 zero held after clear", int'(q0), 0);
    endtask

    task automatic t_illegal();
        load0(4'd12);
        strobe(0);
        chk("R9 illegal up goes to 0", int'(q0), 0);
        load0(4'd14);
        strobe(1);
        chk("R9 illegal down goes to 9", int'(q0), 9);
    endtask

    task automatic t_binary_chain();
        clr1 = 1'b1; idle(2); clr1 = 1'b0; idle(2);
        p1 = 4'd13; ld1 = 1'b0; idle(2); ld1 = 1'b1; idle(1);
        strobe(2); strobe(2);
        chk("R6 binary reaches 15", int'(qlo), 15);
        up1 = 1'b0; idle(10);
        chk("R7 binary carry low", int'(cylo), 0);
        up1 = 1'b1; idle(12);
        chk("R6 binary wrap up", int'(qlo), 0);
        chk("R10 high stage stepped up", int'(qhi), 1);
        dn1 = 1'b0; idle(10);
        chk("R8 binary borrow low", int'(bwlo), 0);
        dn1 = 1'b1; idle(12);
        chk("R6 binary wrap down", int'(qlo), 15);
        chk("R10 high stage stepped down", int'(qhi), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_decade_run();
        t_ignore();
        t_clear_overlap();
        t_illegal();
        t_binary_chain();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule